// File: doc/BRIEF.md
# Selectable-Rate Countdown Timer

This block is an 8-bit binary down counter for a real-time-clock subsystem. Software writes a start value, chooses one of four incoming rate ticks and sets the run bit. Each tick of the chosen rate lowers the count by one. When the count would pass from one to zero, the block raises a sticky expiry flag, reloads the last value software wrote, and keeps counting. The repeat period is therefore n source ticks. An optional interrupt output follows the expiry flag.

The tick rates are not generated here. Four single-cycle enables arrive from a divider elsewhere: a fast rate near 4 kHz, 64 Hz, 1 Hz and a once-per-minute tick. The expiry flag sits in a two-bit status field together with an alarm flag that a neighbouring block sets. Both flags are cleared by an AND-on-write, so software can clear one flag without losing an event on the other.

Top module: `tmr_countdown`

## Requirements
- R1: After reset the count, the reload value, both status flags, the configuration (run 0, interrupt enable 0, source 0) and `irq` are all zero.
- R2: A count write stores `cnt_wdata` as both the count and the reload value, and it is visible on `cnt_rdata` one cycle later. A tick in the same cycle is ignored.
- R3: `cfg_src` value k selects `src_tick[k]` (0 = fast, 1 = 64 Hz, 2 = 1 Hz, 3 = per-minute). A pulse on the selected tick while running lowers a count above one by one. Pulses on the other ticks change nothing.
- R4: While the run bit is 0, ticks leave the count unchanged.
- R5: A selected tick while running with a count of 1 sets status bit 0 (timer flag) and loads the reload value into the count.
- R6: With a count of 0, ticks change nothing and never set the timer flag.
- R7: A status flag stays set until a status write with that bit at 0. A written 1 keeps the flag as it is and never sets it.
- R8: `alarm_evt` sets status bit 1 (alarm flag). It is cleared under the same AND rule, independently of bit 0.
- R9: An expiry or an alarm event in the same cycle as a status write that clears its bit leaves the flag set.
- R10: `irq` is high exactly when the timer flag and the interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | Single-cycle rate enables, index = source code |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Run bit written by `cfg_wr` |
| cfg_irq_en | input | 1 | Interrupt enable written by `cfg_wr` |
| cfg_src | input | 2 | Source select written by `cfg_wr` |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Start value |
| sts_wr | input | 1 | Status write strobe (AND mask) |
| sts_wdata | input | 2 | Mask: bit 0 timer flag, bit 1 alarm flag |
| alarm_evt | input | 1 | Alarm match pulse from the alarm block |
| cnt_rdata | output | 8 | Current count |
| sts_rdata | output | 2 | Bit 0 timer flag, bit 1 alarm flag |
| cfg_rdata | output | 4 | {run, irq enable, source[1:0]} |
| irq | output | 1 | Timer interrupt |

## Verification
Every write, tick and alarm event is applied in one cycle. Its effect on the count, the flags, the configuration and `irq` is due one clock edge later, because each result comes from a single register stage. The bench drives inputs on the falling edge. For every stimulus it pushes the expected state into a queue, stamped with the cycle number in which that state is due. A monitor compares the front entry on the following falling edge, only when the stamp matches the current cycle, so no check looks at a value before its edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 8;
    localparam int SRC_N  = 4;
    localparam int SEL_W  = $clog2(SRC_N);
    localparam int FLAG_N = 2;
    localparam int F_TMR  = 0;
    localparam int F_ALM  = 1;

    typedef struct packed {
        logic             run;
        logic             irq_en;
        logic [SEL_W-1:0] src;
    } cfg_t;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
    import tmr_pkg::*;
(
    input  logic [SRC_N-1:0] ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [SRC_N-1:0] hit;

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign hit[g] = ticks[g] && (sel == SEL_W'(g));
    end

    assign tick = |hit;

    always_comb begin
        assert ($onehot0(hit)) else $error("AST_ONE_SOURCE"); // R3
    end
endmodule

// File: rtl/tmr_down_core.sv
module tmr_down_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rel;
    } core_t;

    core_t st_d, st_q;
    logic  step;

    assign step   = tick && run && !wr;
    assign expire = step && (st_q.cnt == CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.cnt = wdata;
            st_d.rel = wdata;
        end else if (step && st_q.cnt != '0) begin
            st_d.cnt = (st_q.cnt == CNT_W'(1)) ? st_q.rel : st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr) |=> $stable(cnt)); // R4
    AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !wr && cnt == CNT_W'(1)) |=> (cnt == $past(st_q.rel))); // R5
    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !wr) |=> (cnt == '0)); // R6
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt == $past(wdata))); // R2
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_set,
    input  logic              alm_set,
    input  logic              wr,
    input  logic [FLAG_N-1:0] mask,
    output logic [FLAG_N-1:0] flags
);
    logic [FLAG_N-1:0] fl_d, fl_q, set_v;

    always_comb begin
        set_v        = '0;
        set_v[F_TMR] = tmr_set;
        set_v[F_ALM] = alm_set;
        fl_d = (wr ? (fl_q & mask) : fl_q) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[F_TMR] && !wr) |=> flags[F_TMR]); // R7
    AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[F_TMR] && !tmr_set) |=> !flags[F_TMR]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_set |=> flags[F_TMR]); // R9
    AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        alm_set |=> flags[F_ALM]); // R8
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_tick,
    input  logic              cfg_wr,
    input  logic              cfg_run,
    input  logic              cfg_irq_en,
    input  logic [SEL_W-1:0]  cfg_src,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              sts_wr,
    input  logic [FLAG_N-1:0] sts_wdata,
    input  logic              alarm_evt,
    output logic [CNT_W-1:0]  cnt_rdata,
    output logic [FLAG_N-1:0] sts_rdata,
    output logic [SEL_W+1:0]  cfg_rdata,
    output logic              irq
);
    cfg_t cfg_d, cfg_q;
    logic sel_tick, expire;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.run    = cfg_run;
            cfg_d.irq_en = cfg_irq_en;
            cfg_d.src    = cfg_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    tmr_tick_sel u_sel (
        .ticks (src_tick),
        .sel   (cfg_q.src),
        .tick  (sel_tick)
    );

    tmr_down_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sel_tick),
        .run    (cfg_q.run),
        .wr     (cnt_wr),
        .wdata  (cnt_wdata),
        .cnt    (cnt_rdata),
        .expire (expire)
    );

    tmr_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmr_set (expire),
        .alm_set (alarm_evt),
        .wr      (sts_wr),
        .mask    (sts_wdata),
        .flags   (sts_rdata)
    );

    assign cfg_rdata = cfg_q;
    assign irq       = sts_rdata[F_TMR] && cfg_q.irq_en;

    AST_IRQ_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cfg_q.irq_en && !cfg_wr) |=> irq); // R10
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_irq_en) |=> !irq); // R10
endmodule

// File: tb/tmr_countdown_tb_top.sv
module tmr_countdown_tb_top;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        int         due;
        logic [7:0] cnt;
        logic [1:0] sts;
        logic [3:0] cfg;
        logic       irq;
        string      req;
    } exp_t;

    logic       clk = 0, rst_n = 0;
    logic [3:0] src_tick = 0;
    logic       cfg_wr = 0, cfg_run = 0, cfg_irq_en = 0;
    logic [1:0] cfg_src = 0;
    logic       cnt_wr = 0;
    logic [7:0] cnt_wdata = 0;
    logic       sts_wr = 0;
    logic [1:0] sts_wdata = 0;
    logic       alarm_evt = 0;
    logic [7:0] cnt_rdata;
    logic [1:0] sts_rdata;
    logic [3:0] cfg_rdata;
    logic       irq;

    int   cyc = 0, n_cmp = 0, n_bad = 0;
    exp_t q[$];
    logic [7:0] m_cnt = 0, m_rel = 0;
    logic       m_run = 0, m_ie = 0, m_tf = 0, m_af = 0;
    logic [1:0] m_sel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_countdown dut_i (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .cfg_wr(cfg_wr), .cfg_run(cfg_run), .cfg_irq_en(cfg_irq_en), .cfg_src(cfg_src),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .alarm_evt(alarm_evt), .cnt_rdata(cnt_rdata), .sts_rdata(sts_rdata),
        .cfg_rdata(cfg_rdata), .irq(irq)
    );

    task automatic compare(exp_t e);
        n_cmp++;
        if (cnt_rdata !== e.cnt || sts_rdata !== e.sts || cfg_rdata !== e.cfg || irq !== e.irq) begin
            n_bad++;
            $display("FAIL %s: cnt=%0d sts=%b cfg=%b irq=%b, expected cnt=%0d sts=%b cfg=%b irq=%b",
                     e.req, cnt_rdata, sts_rdata, cfg_rdata, irq, e.cnt, e.sts, e.cfg, e.irq);
        end
    endtask

    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) compare(q.pop_front());
    end

    task automatic step(input logic [3:0] tk, input logic cw, input logic crun, input logic cie,
                        input logic [1:0] csrc, input logic nw, input logic [7:0] nd,
                        input logic sw, input logic [1:0] sd, input logic alm, input string req);
        exp_t e;
        logic stp, exp_ev;
        @(negedge clk);
        src_tick = tk; cfg_wr = cw; cfg_run = crun; cfg_irq_en = cie; cfg_src = csrc;
        cnt_wr = nw; cnt_wdata = nd; sts_wr = sw; sts_wdata = sd; alarm_evt = alm;
        stp    = tk[m_sel] && m_run && !nw;
        exp_ev = stp && m_cnt == 8'd1;
        if (nw) begin m_cnt = nd; m_rel = nd; end
        else if (stp && m_cnt != 0) m_cnt = (m_cnt == 8'd1) ? m_rel : m_cnt - 8'd1;
        m_tf = (sw ? (m_tf & sd[0]) : m_tf) | exp_ev;
        m_af = (sw ? (m_af & sd[1]) : m_af) | alm;
        if (cw) begin m_run = crun; m_ie = cie; m_sel = csrc; end
        e.due = cyc + 1; e.cnt = m_cnt; e.sts = {m_af, m_tf};
        e.cfg = {m_run, m_ie, m_sel}; e.irq = m_tf & m_ie; e.req = req;
        q.push_back(e);
    endtask

    task automatic tick(input logic [3:0] tk, input string req);
        step(tk, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        r.due = 0; r.cnt = 0; r.sts = 0; r.cfg = 0; r.irq = 0; r.req = "R1";
        @(negedge clk); compare(r);
        // R2/R3/R5/R10: load 3, run on source 0 with interrupt enabled
        step(0, 0, 0, 0, 0, 1, 8'd3, 0, 0, 0, "R2");
        step(0, 1, 1, 1, 2'd0, 0, 0, 0, 0, 0, "R3");
        tick(4'b0001, "R3");
        tick(4'b0001, "R3");
        tick(4'b0001, "R5");
        tick(4'b0000, "R10");
        // R3: unselected sources do nothing
        tick(4'b1110, "R3");
        // R3: per-minute source
        step(0, 1, 1, 1, 2'd3, 0, 0, 0, 0, 0, "R3");
        tick(4'b1000, "R3");
        tick(4'b0111, "R3");
        // R4: stopped
        step(0, 1, 0, 1, 2'd3, 0, 0, 0, 0, 0, "R4");
        tick(4'b1000, "R4");
        tick(4'b1111, "R4");
        // R2: write beats a same-cycle tick
        step(0, 1, 1, 1, 2'd1, 0, 0, 0, 0, 0, "R2");
        step(4'b0010, 0, 0, 0, 0, 1, 8'd2, 0, 0, 0, "R2");
        // R8: alarm set, R7: clear timer only, then writing 1 does not set
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, 2'b10, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 1, 2'b11, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 1, 2'b01, 0, "R8");
        // R9: expiry while software clears the timer flag
        tick(4'b0010, "R3");
        step(4'b0010, 0, 0, 0, 0, 0, 0, 1, 2'b00, 1, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 2'b00, 0, "R7");
        // R5: n = 1 expires on every tick
        step(0, 0, 0, 0, 0, 1, 8'd1, 0, 0, 0, "R2");
        tick(4'b0010, "R5");
        step(0, 0, 0, 0, 0, 0, 0, 1, 2'b00, 0, "R7");
        tick(4'b0010, "R5");
        // R10: masking the interrupt
        step(0, 1, 1, 0, 2'd1, 0, 0, 0, 0, 0, "R10");
        step(0, 1, 1, 1, 2'd1, 0, 0, 0, 0, 0, "R10");
        // R6: zero count stays idle
        step(0, 0, 0, 0, 0, 1, 8'd0, 1, 2'b00, 0, "R6");
        for (int i = 0; i < 4; i++) tick(4'b1111, "R6");
        // R5: full 8-bit value wraps to reload 255
        step(0, 1, 1, 1, 2'd2, 1, 8'd255, 0, 0, 0, "R2");
        for (int i = 0; i < 255; i++) tick(4'b0100, "R5");
        tick(4'b0000, "R5");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R1: %0d expected items left, expected 0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R1: watchdog expired, got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule